// File: doc/BRIEF.md
# Crystal-Gated Frequency Counter

This block measures the frequency of a conditioned square-wave input by counting its rising edges over a fixed gate window. The window is timed by a slow watch-crystal clock at 32.768 kHz. That clock enters the block as an ordinary signal and is sampled in the system clock domain. A 16-bit gate timer starts from a preload value and counts crystal rising edges. When it rolls over from all ones, it marks the end of a gate and reloads at once, so the gates follow each other with no gap. The default preload of 0x8000 makes each gate exactly 32768 crystal ticks long, which is one second.

Inside a gate, a narrow event counter (8 bits by default) counts the rising edges of the input. A wider tally (16 bits by default) records how many times the event counter has wrapped. At each gate end the tally and the residual count are joined into one word, tally times 2^EVT_W plus residual, which is the frequency in hertz for a one-second gate. The word is latched and announced with a one-cycle valid strobe. Both counters then restart for the next gate. If the input is too fast for the tally, the tally stops at its maximum and a sticky flag records the loss of range.

Top module: `fgc_freq_counter`

## Requirements
- R1: While rst_ni is low, freq_o, freq_valid_o and sat_o are all 0. freq_o stays 0 until the first gate ends.
- R2: A gate lasts exactly 2^GATE_W − PRELOAD rising edges of xtal_i (32768 with the defaults). Consecutive gates are back-to-back, so gate ends are spaced by exactly that many crystal periods.
- R3: freq_valid_o is high for exactly one system clock cycle per gate end and low otherwise.
- R4: Let N be the number of rising edges of sig_i in a gate, with no saturation. The word presented with the valid strobe is tally × 2^EVT_W + residual, where the tally is the high OVF_W bits and the residual is the low EVT_W bits. This word equals N.
- R5: freq_o changes only in the cycle in which freq_valid_o rises. Between strobes it holds its value.
- R6: Both counters clear at every gate end. A gate with no input edges reports 0, even after a gate with many edges.
- R7: An input rising edge detected in the same cycle as a gate end belongs to the next gate. No edge is lost or counted twice, whatever the phase between input and gate.
- R8: The wrap tally saturates at 2^OVF_W − 1. The low EVT_W bits keep wrapping, so a saturated gate reports (2^OVF_W − 1) × 2^EVT_W + (N mod 2^EVT_W).
- R9: sat_o goes high at the first event-counter wrap that finds the tally already at its maximum. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xtal_i | input | 1 | 32.768 kHz crystal clock, sampled as data |
| sig_i | input | 1 | Conditioned signal whose rising edges are counted |
| freq_o | output | OVF_W+EVT_W | Latched frequency word, tally in the high bits |
| freq_valid_o | output | 1 | One-cycle strobe marking a new freq_o |
| sat_o | output | 1 | Sticky flag: the wrap tally ran out of range |

## Verification
A gate timer that reloads with the wrong value, or rolls over one tick early or late, moves the valid strobe. The bench sees this at the very next gate end, because it measures the spacing of every strobe in system cycles. A wrong residual or tally shows up in the word latched at the end of the gate in which the fault occurs. So does a missed clear, a lost boundary edge or a tally that wraps instead of saturating. The burst lengths straddle each multiple of 256, and a periodic input is swept through every phase against the gate end, so such a fault is visible within one or two gates. A flag that is not sticky, or that sets early, appears in the first gate after the tally fills.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

  // Defaults: one-second gate from a 32.768 kHz crystal
  localparam int unsigned DEF_GATE_W  = 16;
  localparam int unsigned DEF_PRELOAD = 32'h0000_8000;
  localparam int unsigned DEF_EVT_W   = 8;
  localparam int unsigned DEF_OVF_W   = 16;
  localparam int unsigned DEF_SYNC    = 2;

  // What the event counter does in a given cycle
  typedef enum logic [1:0] {
    ACT_HOLD      = 2'd0,
    ACT_COUNT     = 2'd1,
    ACT_RESTART_0 = 2'd2,
    ACT_RESTART_1 = 2'd3
  } evt_act_e;

endpackage

// File: rtl/fgc_rst_sync.sv
module fgc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/fgc_edge_sync.sv
module fgc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/fgc_gate_timer.sv
module fgc_gate_timer #(
  parameter int unsigned GATE_W  = 16,
  parameter int unsigned PRELOAD = 32'h0000_8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic gate_end_o
);

  localparam logic [GATE_W-1:0] LOAD_VAL = GATE_W'(PRELOAD);
  localparam logic [GATE_W-1:0] TOP_VAL  = {GATE_W{1'b1}};

  logic [GATE_W-1:0] tmr_q;
  logic [GATE_W-1:0] tmr_d;
  logic              tmr_en;
  logic              at_top;

  always_comb begin
    at_top     = (tmr_q == TOP_VAL);
    gate_end_o = tick_i & at_top;
    tmr_en     = tick_i;
    if (at_top) begin
      tmr_d = LOAD_VAL;
    end else begin
      tmr_d = tmr_q + GATE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= LOAD_VAL;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

endmodule

// File: rtl/fgc_event_count.sv
module fgc_event_count
  import fgc_pkg::*;
#(
  parameter int unsigned EVT_W = 8,
  parameter int unsigned OVF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             gate_end_i,
  output logic [EVT_W-1:0] evt_o,
  output logic [OVF_W-1:0] ovf_o,
  output logic             sat_o
);

  localparam logic [EVT_W-1:0] EVT_MAX = {EVT_W{1'b1}};
  localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

  evt_act_e         act;
  logic [EVT_W-1:0] evt_q, evt_d;
  logic [OVF_W-1:0] ovf_q, ovf_d;
  logic             sat_q;
  logic             cnt_en;
  logic             sat_en;
  logic             wrap;
  logic             ovf_full;

  always_comb begin
    if (gate_end_i) begin
      act = rise_i ? ACT_RESTART_1 : ACT_RESTART_0;
    end else if (rise_i) begin
      act = ACT_COUNT;
    end else begin
      act = ACT_HOLD;
    end
  end

  always_comb begin
    wrap     = (evt_q == EVT_MAX);
    ovf_full = (ovf_q == OVF_MAX);
    evt_d    = evt_q;
    ovf_d    = ovf_q;
    sat_en   = 1'b0;
    unique case (act)
      ACT_COUNT: begin
        evt_d = evt_q + EVT_W'(1);
        if (wrap) begin
          if (ovf_full) begin
            sat_en = 1'b1;
          end else begin
            ovf_d = ovf_q + OVF_W'(1);
          end
        end
      end
      ACT_RESTART_1: begin
        evt_d = EVT_W'(1);
        ovf_d = '0;
      end
      ACT_RESTART_0: begin
        evt_d = '0;
        ovf_d = '0;
      end
      default: begin
        evt_d = evt_q;
        ovf_d = ovf_q;
      end
    endcase
    cnt_en = (act != ACT_HOLD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      ovf_q <= '0;
    end else if (cnt_en) begin
      evt_q <= evt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sat_q <= 1'b0;
    end else if (sat_en) begin
      sat_q <= 1'b1;
    end
  end

  assign evt_o = evt_q;
  assign ovf_o = ovf_q;
  assign sat_o = sat_q;

endmodule

// File: rtl/fgc_freq_counter.sv
module fgc_freq_counter #(
  parameter int unsigned GATE_W      = fgc_pkg::DEF_GATE_W,
  parameter int unsigned PRELOAD     = fgc_pkg::DEF_PRELOAD,
  parameter int unsigned EVT_W       = fgc_pkg::DEF_EVT_W,
  parameter int unsigned OVF_W       = fgc_pkg::DEF_OVF_W,
  parameter int unsigned SYNC_STAGES = fgc_pkg::DEF_SYNC
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   xtal_i,
  input  logic                   sig_i,
  output logic [OVF_W+EVT_W-1:0] freq_o,
  output logic                   freq_valid_o,
  output logic                   sat_o
);

  localparam int unsigned RES_W    = OVF_W + EVT_W;
  localparam int unsigned N_IN     = 2;
  localparam int unsigned IDX_TICK = 0;
  localparam int unsigned IDX_SIG  = 1;

  logic             rst_sync_n;
  logic [N_IN-1:0]  raw_in;
  logic [N_IN-1:0]  rise_vec;
  logic             tick;
  logic             sig_rise;
  logic             gate_end;
  logic [EVT_W-1:0] evt_cnt;
  logic [OVF_W-1:0] ovf_cnt;
  logic [RES_W-1:0] res_q, res_d;
  logic             res_en;
  logic             valid_q, valid_d;

  fgc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  assign raw_in = {sig_i, xtal_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_in_sync
    fgc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .async_i (raw_in[g]),
      .rise_o  (rise_vec[g])
    );
  end

  assign tick     = rise_vec[IDX_TICK];
  assign sig_rise = rise_vec[IDX_SIG];

  fgc_gate_timer #(.GATE_W(GATE_W), .PRELOAD(PRELOAD)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .tick_i     (tick),
    .gate_end_o (gate_end)
  );

  fgc_event_count #(.EVT_W(EVT_W), .OVF_W(OVF_W)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .rise_i     (sig_rise),
    .gate_end_i (gate_end),
    .evt_o      (evt_cnt),
    .ovf_o      (ovf_cnt),
    .sat_o      (sat_o)
  );

  // Tally times 2^EVT_W plus residual is a plain concatenation
  always_comb begin
    res_d   = {ovf_cnt, evt_cnt};
    res_en  = gate_end;
    valid_d = gate_end;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign freq_o       = res_q;
  assign freq_valid_o = valid_q;

endmodule

// File: rtl/fgc_freq_counter_chk.sv
module fgc_freq_counter_chk #(
  parameter int unsigned EVT_W = 8,
  parameter int unsigned OVF_W = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   gate_end,
  input logic                   sig_rise,
  input logic [EVT_W-1:0]       evt_cnt,
  input logic [OVF_W-1:0]       ovf_cnt,
  input logic [OVF_W+EVT_W-1:0] freq_o,
  input logic                   freq_valid_o,
  input logic                   sat_o
);

  localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

  assert_valid_after_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_end |=> freq_valid_o);

  assert_valid_needs_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_valid_o |-> $past(gate_end));

  assert_valid_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_valid_o |=> !freq_valid_o);

  assert_word_compose_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_end |=> (freq_o == {$past(ovf_cnt), $past(evt_cnt)}));

  assert_word_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_end |=> $stable(freq_o));

  assert_clear_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_end && !sig_rise) |=> (evt_cnt == '0 && ovf_cnt == '0));

  assert_boundary_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_end && sig_rise) |=> (evt_cnt == EVT_W'(1) && ovf_cnt == '0));

  assert_tally_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_cnt == OVF_MAX && !gate_end) |=> (ovf_cnt == OVF_MAX));

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |=> sat_o);

  assert_flag_needs_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_o) |-> ($past(ovf_cnt) == OVF_MAX));

endmodule

bind fgc_freq_counter fgc_freq_counter_chk #(.EVT_W(EVT_W), .OVF_W(OVF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .gate_end     (gate_end),
  .sig_rise     (sig_rise),
  .evt_cnt      (evt_cnt),
  .ovf_cnt      (ovf_cnt),
  .freq_o       (freq_o),
  .freq_valid_o (freq_valid_o),
  .sat_o        (sat_o)
);

// File: tb/fgc_freq_counter_test.sv
module fgc_freq_counter_test;

  localparam int unsigned GATE_W   = 16;
  localparam int unsigned PRELOAD  = 32'h0000_FC00;  // 1024 ticks per gate
  localparam int unsigned EVT_W    = 8;
  localparam int unsigned OVF_W    = 2;
  localparam int unsigned RES_W    = OVF_W + EVT_W;
  localparam int          TICK_CYC = 4;
  localparam int          GATE_CYC = TICK_CYC * ((1 << GATE_W) - PRELOAD);
  localparam int          NV       = 12;

  // Burst length per gate, expected word and expected flag
  localparam int unsigned VEC_N   [NV] = '{1, 37, 255, 256, 257, 511, 512, 700, 0, 1023, 1024, 1300};
  localparam int unsigned VEC_EXP [NV] = '{1, 37, 255, 256, 257, 511, 512, 700, 0, 1023,  768,  788};
  localparam bit          VEC_SAT [NV] = '{0,  0,   0,   0,   0,   0,   0,   0, 0,    0,    1,    1};

  logic             clk;
  logic             rst_n;
  logic             xtal;
  logic             sig;
  logic [RES_W-1:0] freq;
  logic             valid;
  logic             sat;

  int n_chk;
  int n_bad;
  int burst_left;
  int half;
  int phase;
  bit per_en;
  bit hold_req;
  bit hung;
  int last_cyc;

  fgc_freq_counter #(
    .GATE_W(GATE_W), .PRELOAD(PRELOAD), .EVT_W(EVT_W), .OVF_W(OVF_W), .SYNC_STAGES(2)
  ) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .xtal_i       (xtal),
    .sig_i        (sig),
    .freq_o       (freq),
    .freq_valid_o (valid),
    .sat_o        (sat)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  initial begin
    xtal = 1'b0;
    forever begin
      repeat (TICK_CYC / 2) @(negedge clk);
      xtal = ~xtal;
    end
  end

  // Input generator: bursts of pulses or a free-running square wave
  initial begin
    sig   = 1'b0;
    phase = 0;
    forever begin
      @(negedge clk);
      if (hold_req) begin
        hold_req = 1'b0;
      end else if (per_en || burst_left > 0) begin
        if (phase >= half - 1) begin
          phase = 0;
          sig   = ~sig;
          if (!sig && burst_left > 0) burst_left = burst_left - 1;
        end else begin
          phase = phase + 1;
        end
      end else begin
        sig   = 1'b0;
        phase = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for the next strobe; checks that freq did not move before it
  task automatic wait_valid(input bit chk_int);
    int          cyc;
    bit          moved;
    logic [RES_W-1:0] held;
    cyc   = 0;
    moved = 1'b0;
    held  = freq;
    do begin
      @(negedge clk);
      cyc++;
      if (!valid && freq !== held) moved = 1'b1;
    end while (!valid && !hung);
    last_cyc = cyc;
    check(!moved, "R5 word held between strobes", int'(moved), 0);
    if (chk_int) check(cyc == GATE_CYC, "R2 R3 strobe spacing", cyc, GATE_CYC);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    hung = 1'b1;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; burst_left = 0; half = 1;
    per_en = 1'b0; hold_req = 1'b0; hung = 1'b0; last_cyc = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(freq == '0, "R1 reset word", int'(freq), 0);
    check(valid == 1'b0, "R1 reset strobe", int'(valid), 0);
    check(sat == 1'b0, "R1 reset flag", int'(sat), 0);
    rst_n = 1'b1;

    // First gate: no edges, word stays 0 until the strobe, then reports 0
    wait_valid(1'b0);
    check(freq == '0, "R1 R6 first gate word", int'(freq), 0);

    // Vector table: one burst per gate
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      half       = 1;
      burst_left = VEC_N[i];
      wait_valid(1'b1);
      check(freq == RES_W'(VEC_EXP[i]), "R4 R6 R8 gate word", int'(freq), int'(VEC_EXP[i]));
      check(sat == VEC_SAT[i], "R9 range flag", int'(sat), int'(VEC_SAT[i]));
    end

    // Phase sweep of a period-8 input against the gate end
    @(posedge clk);
    half   = 4;
    per_en = 1'b1;
    wait_valid(1'b1);
    for (int off = 0; off < 8; off++) begin
      @(posedge clk);
      hold_req = 1'b1;
      wait_valid(1'b1);
      wait_valid(1'b1);
      check(freq == RES_W'(GATE_CYC / 8), "R7 boundary edge phase", int'(freq), GATE_CYC / 8);
      check(sat == 1'b1, "R9 flag still set", int'(sat), 1);
    end

    // Reset in mid-run clears the flag; the first gate after it is full length
    @(posedge clk);
    per_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(freq == '0, "R1 async reset word", int'(freq), 0);
    check(sat == 1'b0, "R1 R9 reset clears flag", int'(sat), 0);
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1 strobe in reset", int'(valid), 0);
    rst_n = 1'b1;
    wait_valid(1'b0);
    check(last_cyc >= GATE_CYC && last_cyc <= GATE_CYC + 12, "R2 first gate after reset",
          last_cyc, GATE_CYC);
    check(freq == '0, "R6 idle gate after reset", int'(freq), 0);
    @(negedge clk);
    check(valid == 1'b0, "R3 strobe drops", int'(valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule